// File: doc/BRIEF.md
# Hash DRBG Sequencing Controller

This block is the control and state-keeping part of a hash-based deterministic random bit generator. It holds the working value V, the constant C, a reseed counter, a personalization string and an entropy buffer. It carries out three commands (instantiate, reseed and generate) by issuing 512-bit blocks to an external hash engine over a one-cycle start pulse and a done pulse. The engine samples the block when it is started and returns a 256-bit digest a fixed number of cycles later.

Wide additions over the seed width go to an internal serial adder. The adder works on one chunk per cycle and is started together with a hash, so its latency is hidden behind the hash latency. Random output leaves as 256-bit words under a valid/ready handshake.

A command is offered with `cmd_valid` and is taken only while the controller is idle. `busy` stays high until the command has completed. Misuse is answered with a one-cycle `err` pulse and no state change. Misuse means generate or reseed before any instantiate, or generate once the counter has saturated.

Top module: `drbg_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `err`, `reseed_req`, `hash_start` and `rnd_valid` are all low.
- R2: A command is taken only on a clock edge where `cmd_valid` is high and the controller is idle. `busy` rises in the next cycle and stays high until the command ends. `cmd_valid` offered while busy has no effect and produces no `err`. Op codes on `cmd_op`: 1 = instantiate, 2 = reseed, 3 = generate, 0 = none.
- R3: Generate or reseed offered before any instantiate is refused. `err` is high for exactly the one cycle after the accepting edge, `busy` stays low and no hash is started.
- R4: Instantiate latches `entropy` and `pers` and sets the material M = entropy XOR (pers placed in bits 511:384). The first block is issued in the cycle after acceptance. The blocks are M XOR (index in bits 511:504) for index 1, then index 2. The new V is the top SEED_W bits of D1 concatenated with D2.
- R5: C is then derived from blocks {index, 8'h00, V, zeros} for index 1 and 2, truncated the same way. The counter is set to 1.
- R6: Reseed works like R4 and R5, except that M = entropy XOR (V placed in bits 511:72) and `pers` is not used.
- R7: Generate of n words (`cmd_words`, zero allowed) sets a working copy W = V. Word k is the digest of block {W+k, 72 zero bits}. Each word is held stable on `rnd_data` with `rnd_valid` high until `rnd_ready` is seen.
- R8: After the words, V becomes V + C + H({8'h03, V, 64 zero bits}) + counter, modulo 2^SEED_W, and the counter increments.
- R9: When the counter equals 2^CNT_W−1, `reseed_req` is high and generate is refused with a one-cycle `err`, with no state change. A reseed clears the condition.
- R10: `hash_start` is a single-cycle pulse. `rnd_valid` rises exactly LAT+1 cycles after the cycle in which the hash for that word was started.
- R11: The increment of W and the V+C sum run on the serial adder while the hash is outstanding. Each addition takes SEED_W/CHUNK_W cycles and has finished by the time the overlapping digest returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Command code: 1 instantiate, 2 reseed, 3 generate |
| cmd_words | input | WORDS_W | Number of output words for generate |
| entropy | input | ENT_W | Entropy input for instantiate and reseed |
| pers | input | PERS_W | Personalization string for instantiate |
| busy | output | 1 | Command in progress |
| err | output | 1 | One-cycle pulse on a refused command |
| reseed_req | output | 1 | Counter saturated; reseed needed |
| hash_start | output | 1 | Start pulse to the hash engine |
| hash_block | output | BLK_W | Block for the hash engine, valid with hash_start |
| hash_done | input | 1 | Digest ready pulse from the hash engine |
| hash_digest | input | DIG_W | Digest from the hash engine |
| rnd_valid | output | 1 | Random word available |
| rnd_ready | input | 1 | Consumer takes the word |
| rnd_data | output | DIG_W | Random word |

## Verification
The `err` pulse for a refused command is due in the one cycle right after the accepting edge. The first derivation block appears on `hash_block` in that same cycle. Each random word arrives LAT+1 cycles after its hash start, and the bench measures this with a free-running cycle count stamped at the start. The state updates of R4 to R8 are seen only through the next generate's output words, which the bench predicts with its own model of V, C and the counter. All inputs change and all outputs are sampled on falling edges, so each check reads a value that was settled by the preceding rising edge.

// File: rtl/drbg_seq_pkg.sv
package drbg_seq_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_INST   = 2'd1,
        OP_RESEED = 2'd2,
        OP_GEN    = 2'd3
    } drbg_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DF_A, ST_DF_A_W, ST_DF_B, ST_DF_B_W,
        ST_C_A, ST_C_A_W, ST_C_B, ST_C_B_W,
        ST_G_ISS, ST_G_WAIT, ST_G_OUT,
        ST_U_ISS, ST_U_WAIT, ST_U_SUM1, ST_U_SUM2
    } drbg_st_e;
endpackage

// File: rtl/drbg_serial_add.sv
module drbg_serial_add #(
    parameter int W  = 440,
    parameter int CW = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] sum
);
    localparam int NCH = W / CW;
    localparam int IW  = $clog2(NCH + 1);

    typedef struct packed {
        logic [W-1:0]  acc;
        logic [W-1:0]  addend;
        logic          carry;
        logic [IW-1:0] left;
        logic          done;
    } add_regs_t;

    add_regs_t q, d;
    logic [CW:0] part;

    always_comb begin
        d    = q;
        part = {1'b0, q.acc[CW-1:0]} + {1'b0, q.addend[CW-1:0]} + {{CW{1'b0}}, q.carry};
        d.done = 1'b0;
        if (start) begin
            d.acc    = op_a;
            d.addend = op_b;
            d.carry  = 1'b0;
            d.left   = IW'(NCH);
        end else if (q.left != '0) begin
            // rotate the finished chunk into the top; after NCH steps the word is aligned again
            d.acc    = {part[CW-1:0], q.acc[W-1:CW]};
            d.addend = q.addend >> CW;
            d.carry  = part[CW];
            d.left   = q.left - IW'(1);
            d.done   = (q.left == IW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.left != '0);
    assign done = q.done;
    assign sum  = q.acc;

    p_start_runs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    p_done_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/drbg_seq_ctrl.sv
module drbg_seq_ctrl
    import drbg_seq_pkg::*;
#(
    parameter int SEED_W  = 440,
    parameter int CNT_W   = 20,
    parameter int ENT_W   = 512,
    parameter int PERS_W  = 128,
    parameter int BLK_W   = 512,
    parameter int DIG_W   = 256,
    parameter int CHUNK_W = 40,
    parameter int WORDS_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [WORDS_W-1:0] cmd_words,
    input  logic [ENT_W-1:0]   entropy,
    input  logic [PERS_W-1:0]  pers,
    output logic               busy,
    output logic               err,
    output logic               reseed_req,
    output logic               hash_start,
    output logic [BLK_W-1:0]   hash_block,
    input  logic               hash_done,
    input  logic [DIG_W-1:0]   hash_digest,
    output logic               rnd_valid,
    input  logic               rnd_ready,
    output logic [DIG_W-1:0]   rnd_data
);
    localparam int W_PAD   = BLK_W - SEED_W;
    localparam int C_PAD   = BLK_W - 16 - SEED_W;
    localparam int U_PAD   = BLK_W - 8 - SEED_W;
    localparam int IDX_LO  = BLK_W - 8;
    localparam int CAT_SH  = 2 * DIG_W - SEED_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        drbg_st_e           st;
        logic [SEED_W-1:0]  v;
        logic [SEED_W-1:0]  c;
        logic [SEED_W-1:0]  w;
        logic [CNT_W-1:0]   cnt;
        logic               inst_ok;
        logic               is_inst;
        logic [ENT_W-1:0]   ent;
        logic [PERS_W-1:0]  pers;
        logic [WORDS_W-1:0] left;
        logic [DIG_W-1:0]   d1;
        logic               err;
        logic               rv;
        logic [DIG_W-1:0]   rd;
    } ctrl_regs_t;

    ctrl_regs_t q, d;
    logic [ENT_W-1:0]  mat;
    logic              add_start, add_busy, add_done;
    logic [SEED_W-1:0] add_a, add_b, add_sum;

    drbg_serial_add #(.W(SEED_W), .CW(CHUNK_W)) u_add (
        .clk(clk), .rst_n(rst_n), .start(add_start), .op_a(add_a), .op_b(add_b),
        .busy(add_busy), .done(add_done), .sum(add_sum)
    );

    always_comb begin
        d          = q;
        d.err      = 1'b0;
        hash_start = 1'b0;
        hash_block = '0;
        add_start  = 1'b0;
        add_a      = q.w;
        add_b      = '0;
        mat = q.is_inst ? (q.ent ^ {q.pers, {(ENT_W-PERS_W){1'b0}}})
                        : (q.ent ^ {q.v, {(ENT_W-SEED_W){1'b0}}});
        case (q.st)
            ST_IDLE: if (cmd_valid) begin
                case (drbg_op_e'(cmd_op))
                    OP_INST: begin
                        d.ent = entropy; d.pers = pers; d.is_inst = 1'b1; d.st = ST_DF_A;
                    end
                    OP_RESEED: begin
                        if (!q.inst_ok) d.err = 1'b1;
                        else begin d.ent = entropy; d.is_inst = 1'b0; d.st = ST_DF_A; end
                    end
                    OP_GEN: begin
                        if (!q.inst_ok || q.cnt == CNT_MAX) d.err = 1'b1;
                        else begin
                            d.w    = q.v;
                            d.left = cmd_words;
                            d.st   = (cmd_words == '0) ? ST_U_ISS : ST_G_ISS;
                        end
                    end
                    default: ;
                endcase
            end
            ST_DF_A: begin
                hash_start = 1'b1;
                hash_block = mat ^ {8'h01, {IDX_LO{1'b0}}};
                d.st = ST_DF_A_W;
            end
            ST_DF_A_W: if (hash_done) begin d.d1 = hash_digest; d.st = ST_DF_B; end
            ST_DF_B: begin
                hash_start = 1'b1;
                hash_block = mat ^ {8'h02, {IDX_LO{1'b0}}};
                d.st = ST_DF_B_W;
            end
            ST_DF_B_W: if (hash_done) begin
                d.v  = SEED_W'({q.d1, hash_digest} >> CAT_SH);
                d.st = ST_C_A;
            end
            ST_C_A: begin
                hash_start = 1'b1;
                hash_block = {8'h01, 8'h00, q.v, {C_PAD{1'b0}}};
                d.st = ST_C_A_W;
            end
            ST_C_A_W: if (hash_done) begin d.d1 = hash_digest; d.st = ST_C_B; end
            ST_C_B: begin
                hash_start = 1'b1;
                hash_block = {8'h02, 8'h00, q.v, {C_PAD{1'b0}}};
                d.st = ST_C_B_W;
            end
            ST_C_B_W: if (hash_done) begin
                d.c       = SEED_W'({q.d1, hash_digest} >> CAT_SH);
                d.cnt     = CNT_W'(1);
                d.inst_ok = 1'b1;
                d.st      = ST_IDLE;
            end
            ST_G_ISS: begin
                hash_start = 1'b1;
                hash_block = {q.w, {W_PAD{1'b0}}};
                add_start  = 1'b1;
                add_a      = q.w;
                add_b      = SEED_W'(1);
                d.st       = ST_G_WAIT;
            end
            ST_G_WAIT: if (hash_done) begin d.rv = 1'b1; d.rd = hash_digest; d.st = ST_G_OUT; end
            ST_G_OUT: if (rnd_ready) begin
                d.rv   = 1'b0;
                d.w    = add_sum;
                d.left = q.left - WORDS_W'(1);
                d.st   = (q.left == WORDS_W'(1)) ? ST_U_ISS : ST_G_ISS;
            end
            ST_U_ISS: begin
                hash_start = 1'b1;
                hash_block = {8'h03, q.v, {U_PAD{1'b0}}};
                add_start  = 1'b1;
                add_a      = q.v;
                add_b      = q.c;
                d.st       = ST_U_WAIT;
            end
            ST_U_WAIT: if (hash_done) begin
                add_start = 1'b1;
                add_a     = add_sum;
                add_b     = {{(SEED_W-DIG_W){1'b0}}, hash_digest};
                d.st      = ST_U_SUM1;
            end
            ST_U_SUM1: if (add_done) begin
                add_start = 1'b1;
                add_a     = add_sum;
                add_b     = {{(SEED_W-CNT_W){1'b0}}, q.cnt};
                d.st      = ST_U_SUM2;
            end
            ST_U_SUM2: if (add_done) begin
                d.v   = add_sum;
                d.cnt = q.cnt + CNT_W'(1);
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = (q.st != ST_IDLE);
    assign err        = q.err;
    assign reseed_req = q.inst_ok && (q.cnt == CNT_MAX);
    assign rnd_valid  = q.rv;
    assign rnd_data   = q.rd;

    p_busy_from_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
    p_err_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    p_word_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_valid && !rnd_ready) |=> (rnd_valid && $stable(rnd_data)));
    p_sat_refuses_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reseed_req && !busy && cmd_valid && cmd_op == 2'd3) |=> (err && !busy));
    p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start);
    p_adder_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hash_done |-> !add_busy);
endmodule

// File: tb/drbg_seq_ctrl_bench.sv
module drbg_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 64;
    localparam int CNTW       = 3;
    localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic [7:0]   cmd_words = '0;
    logic [511:0] entropy = '0;
    logic [127:0] pers = '0;
    logic         busy, err, reseed_req, hash_start, hash_done, rnd_valid;
    logic         rnd_ready = 1'b0;
    logic [511:0] hash_block;
    logic [255:0] hash_digest, rnd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    drbg_seq_ctrl #(.CNT_W(CNTW)) u_drbg_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_words(cmd_words), .entropy(entropy), .pers(pers), .busy(busy),
        .err(err), .reseed_req(reseed_req), .hash_start(hash_start),
        .hash_block(hash_block), .hash_done(hash_done), .hash_digest(hash_digest),
        .rnd_valid(rnd_valid), .rnd_ready(rnd_ready), .rnd_data(rnd_data)
    );

    function automatic logic [255:0] mock_h(input logic [511:0] b);
        return b[511:256] ^ {b[248:0], b[255:249]} ^ {8{32'h9E37_79B9}};
    endfunction

    // mock hash engine: samples the block at start, done LAT cycles later
    int unsigned  cyc = 0;
    int unsigned  last_start = 0;
    int           hcnt = 0;
    logic [511:0] blk_q = '0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (hash_start) begin
            blk_q      <= hash_block;
            hcnt       <= LAT;
            last_start <= cyc;
        end else if (hcnt != 0) hcnt <= hcnt - 1;
    end
    assign hash_done   = (hcnt == 1);
    assign hash_digest = mock_h(blk_q);

    // reference state
    logic [439:0]    v_m = '0, c_m = '0;
    logic [CNTW-1:0] cnt_m = '0;
    bit              inst_m = 1'b0;

    function automatic logic [439:0] trunc2(input logic [255:0] a, input logic [255:0] b);
        logic [511:0] t;
        t = {a, b};
        return t[511:72];
    endfunction

    function automatic logic [439:0] derive_v(input logic [511:0] m);
        return trunc2(mock_h(m ^ {8'h01, 504'b0}), mock_h(m ^ {8'h02, 504'b0}));
    endfunction

    function automatic logic [439:0] derive_c(input logic [439:0] v);
        return trunc2(mock_h({8'h01, 8'h00, v, 56'b0}), mock_h({8'h02, 8'h00, v, 56'b0}));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [7:0] n,
                            input logic [511:0] e, input logic [127:0] p);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_words = n; entropy = e; pers = p;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 20000) begin @(negedge clk); t++; end
        check(!busy, "R2", "command finishes", busy, 0);
    endtask

    task automatic expect_refusal(input string req);
        check(err == 1'b1, req, "err pulse", err, 1);
        check(!busy && !hash_start, req, "no work started", {busy, hash_start}, 0);
        @(negedge clk);
        check(err == 1'b0, req, "err one cycle only", err, 0);
    endtask

    task automatic do_inst(input logic [511:0] e, input logic [127:0] p, input bit poke);
        logic [511:0] m;
        m = e ^ {p, 384'b0};
        send_cmd(2'd1, 8'd0, e, p);
        check(busy == 1'b1, "R2", "busy after accept", busy, 1);
        check(hash_start && hash_block == (m ^ {8'h01, 504'b0}), "R4", "first instantiate block",
              hash_block, m ^ {8'h01, 504'b0});
        if (poke) begin
            for (int i = 0; i < 5; i++) begin
                cmd_valid = 1'b1; cmd_op = 2'd1; entropy = ~e; pers = ~p;
                @(negedge clk);
                check(busy && !err, "R2", "command while busy ignored", {busy, err}, 2'b10);
            end
            cmd_valid = 1'b0; cmd_op = 2'd0;
        end
        wait_idle();
        v_m = derive_v(m); c_m = derive_c(v_m); cnt_m = 1; inst_m = 1'b1;
        check(reseed_req == 1'b0, "R5", "counter restarts", reseed_req, 0);
    endtask

    task automatic do_reseed(input logic [511:0] e);
        logic [511:0] m;
        m = e ^ {v_m, 72'b0};
        send_cmd(2'd2, 8'd0, e, 128'hDEAD);
        if (!inst_m) begin expect_refusal("R3"); return; end
        check(hash_start && hash_block == (m ^ {8'h01, 504'b0}), "R6", "first reseed block",
              hash_block, m ^ {8'h01, 504'b0});
        wait_idle();
        v_m = derive_v(m); c_m = derive_c(v_m); cnt_m = 1;
        check(reseed_req == 1'b0, "R9", "reseed clears request", reseed_req, 0);
    endtask

    task automatic do_gen(input int n, input int stall);
        logic [439:0] w;
        logic [255:0] exp;
        bit           refuse;
        refuse = !inst_m || (cnt_m == CMAX);
        send_cmd(2'd3, 8'(n), '0, '0);
        if (refuse) begin
            expect_refusal(inst_m ? "R9" : "R3");
            return;
        end
        w = v_m;
        for (int k = 0; k < n; k++) begin
            int t = 0;
            while (!rnd_valid && t < 1000) begin @(negedge clk); t++; end
            exp = mock_h({w, 72'b0});
            check(cyc - last_start == LAT + 1, "R10", "word latency", cyc - last_start, LAT + 1);
            check(rnd_data == exp, (k == 0) ? "R7" : "R11", "word value", rnd_data, exp);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check(rnd_valid && rnd_data == exp, "R7", "word held under stall", rnd_data, exp);
            end
            rnd_ready = 1'b1;
            @(negedge clk);
            rnd_ready = 1'b0;
            w = w + 440'd1;
        end
        wait_idle();
        v_m = v_m + c_m + {184'b0, mock_h({8'h03, v_m, 64'b0})} + {437'b0, cnt_m};
        cnt_m = cnt_m + 1'b1;
        check(reseed_req == (cnt_m == CMAX), "R9", "request level", reseed_req, cnt_m == CMAX);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !err && !reseed_req, "R1", "reset outputs", {busy, err, reseed_req}, 0);
        check(!hash_start && !rnd_valid, "R1", "reset handshakes", {hash_start, rnd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_gen(1, 0);                          // R3 refused before instantiate
        do_reseed({16{32'h1357_9BDF}});        // R3 refused before instantiate
        do_inst({16{32'hA5C3_0F1E}}, {4{32'h0BAD_F00D}}, 1'b1);
        do_gen(2, 0);                          // R7 R8 R11
        do_gen(0, 0);                          // R8 update only
        do_gen(3, 2);                          // R7 stall
        do_reseed({16{32'h7E11_C0DE}});        // R6
        for (int i = 0; i < 6; i++) do_gen(1, 0);
        check(reseed_req == 1'b1, "R9", "saturated counter", reseed_req, 1);
        do_gen(1, 0);                          // R9 refused
        do_reseed({8{64'h0F0F_3C3C_5A5A_9696}});
        do_gen(2, 1);                          // state intact after refusal
        do_inst({16{32'h2468_ACE0}}, {4{32'h5555_AAAA}}, 1'b0);
        do_gen(1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule